// File: doc/BRIEF.md
# Transition-to-Return-to-Zero Handshake Bridge

This block takes bundled data off a link that uses transition signalling and hands it on over a link that uses a level-based return-to-zero handshake. On the input link a token is waiting whenever the request level and the acknowledge level differ. The link is empty when the two levels match. On the output link the request is held high while the data is valid. The receiver raises its acknowledge once it has taken the data. Both wires then go back to low.

The bridge is clocked and holds one word. When it is idle and sees a waiting token, it loads the word and flips its input acknowledge in the same clock edge. It then runs one complete four-step cycle on the output: raise the request, wait for the acknowledge to go high, drop the request, and wait for the acknowledge to go low. It looks at the input again only after this cycle ends. Each flip of the input request therefore produces exactly one output cycle. The data wires carry plain binary values with no encoding.

Top module: `phase_bridge`

## Requirements
- R1: After synchronous active-low reset, `in_ack` is 0, `out_req` is 0 and `out_data` is all zeros.
- R2: When the bridge is idle and `in_req` differs from `in_ack` at a rising edge, then after that edge `out_data` holds the `in_data` sampled at that edge, `in_ack` equals `in_req`, and `out_req` is 1.
- R3: `in_ack` changes only at an edge where a word is captured, and each such change is paired with a rise of `out_req` in the same cycle.
- R4: Once raised, `out_req` stays high until `out_ack` is sampled high. It is low in the cycle after that edge and stays low until the next capture.
- R5: No new token is taken while the output cycle is active, that is, while `out_req` or `out_ack` is high. The earliest capture is at the second edge after `out_ack` is sampled low.
- R6: `out_data` does not change from the rise of `out_req` until `out_ack` has been seen high, even if `in_data` changes in that time.
- R7: The number of rises of `out_req` equals the number of transitions of `in_req`.
- R8: While the input link is empty (`in_req` equals `in_ack`), changes of `in_data` have no effect on `out_data`, `out_req` or `in_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_req | input | 1 | Input request level; it flips once per token |
| in_ack | output | 1 | Input acknowledge level; it flips when a word is captured |
| in_data | input | W | Input data, bundled with `in_req` |
| out_req | output | 1 | Output request; high while `out_data` is valid |
| out_ack | input | 1 | Output acknowledge, return-to-zero |
| out_data | output | W | Captured word sent to the output link |

## Verification
The bench sends tokens while sweeping every combination of 0 to 3 cycles of acknowledge-rise delay and 0 to 3 cycles of acknowledge-fall delay. These runs separate a request that drops too early from one that drops too late. In half of the runs the next token arrives while the previous output cycle is still active; these runs show whether the bridge starts that token early or, as required, waits for the return to idle. It scrambles `in_data` while a word is in flight, and again while the input link is empty, to show that the captured word is held. At the end it compares the total number of output request rises with the number of input transitions.

// File: rtl/bridge_pkg.sv
// Shared types for the handshake bridge.
package bridge_pkg;
    // Output-side sequencer state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for an input token
        ST_RAISE = 2'd1,   // request high, waiting for acknowledge high
        ST_DROP  = 2'd2    // request low, waiting for acknowledge low
    } seq_state_t;
endpackage

// File: rtl/bridge_in_track.sv
// Tracks the transition-signalled input link.
// Holds the acknowledge level and reports FULL while the request level differs from it.
// Assumes in_req changes only when the link is empty.
module bridge_in_track (
    input  logic clk,
    input  logic rst_n,
    input  logic in_req,
    input  logic take,
    output logic ack_lvl,
    output logic full
);
    logic ack_q;

    // Acknowledge level: flips on every capture
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else if (take)
            ack_q <= ~ack_q;
    end

    // Link state: a level mismatch means a token is waiting
    always_comb begin
        full    = in_req ^ ack_q;
        ack_lvl = ack_q;
    end
endmodule

// File: rtl/bridge_capture.sv
// Word register that holds the bundled data.
// Loads on a capture strobe and otherwise holds its value.
module bridge_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Data register: load on capture, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/bridge_out_seq.sv
// Sequencer for the return-to-zero output handshake.
// Captures a token only from idle, then waits for the acknowledge to rise and then to fall.
// Assumes the receiver raises ack only while req is high.
module bridge_out_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic tok_full,
    input  logic out_ack,
    output logic take,
    output logic out_req
);
    import bridge_pkg::*;

    seq_state_t st_q, st_d;

    // Next-state logic for the output handshake
    always_comb begin
        st_d = st_q;
        take = 1'b0;
        case (st_q)
            ST_IDLE: if (tok_full) begin
                take = 1'b1;
                st_d = ST_RAISE;
            end
            ST_RAISE: if (out_ack) st_d = ST_DROP;
            ST_DROP:  if (!out_ack) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Request output is a direct decode of the state
    always_comb out_req = (st_q == ST_RAISE);
endmodule

// File: rtl/phase_bridge.sv
// Top of the bridge from transition signalling to return-to-zero signalling.
// Holds one token. It flips the input acknowledge when it captures the word, then runs one full
// output cycle before it takes the next token.
// Assumes the two sides share clk and follow their protocols.
module phase_bridge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_req,
    output logic         in_ack,
    input  logic [W-1:0] in_data,
    output logic         out_req,
    input  logic         out_ack,
    output logic [W-1:0] out_data
);
    logic full;
    logic take;

    bridge_in_track u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (in_req),
        .take    (take),
        .ack_lvl (in_ack),
        .full    (full)
    );

    bridge_capture #(.W(W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take),
        .d     (in_data),
        .q     (out_data)
    );

    bridge_out_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_full (full),
        .out_ack  (out_ack),
        .take     (take),
        .out_req  (out_req)
    );
endmodule

// File: rtl/bridge_checker.sv
// Protocol checker for phase_bridge. It looks only at the ports.
module bridge_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_req,
    input logic         in_ack,
    input logic         out_req,
    input logic         out_ack,
    input logic [W-1:0] out_data
);
    // R2: a new request rise follows a waiting input token
    p_rise_needs_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req) |-> $past(in_req != in_ack));

    // R3: the input acknowledge changes only together with a request rise
    p_ack_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack != $past(in_ack)) |-> $rose(out_req));

    // R4: the request holds until the acknowledge is seen high
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack) |=> out_req);

    // R5: no capture while the output cycle is active
    p_no_take_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req || out_ack) |=> $stable(in_ack));

    // R6: data stays stable while it is offered
    p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && !out_ack) |=> $stable(out_data));
endmodule

bind phase_bridge bridge_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_ack  (out_ack),
    .out_data (out_data)
);

// File: tb/sim_phase_bridge.sv
module sim_phase_bridge;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_req = 1'b0;
    logic         in_ack;
    logic [W-1:0] in_data = '0;
    logic         out_req;
    logic         out_ack = 1'b0;
    logic [W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int n_tog = 0;
    int n_rise = 0;
    logic prev_req = 1'b0;
    logic pending = 1'b0;
    logic [W-1:0] pend_data = '0;

    always #5 clk = ~clk;

    phase_bridge #(.W(W)) u0 (.*);

    // count rises of the output request, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && out_req && !prev_req) n_rise++;
        prev_req <= out_req;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one token through the bridge; the call starts and ends on a falling edge
    task automatic token(input logic [W-1:0] d, input int rd, input int fd,
                         input bit early, input logic [W-1:0] d2);
        logic a0;
        logic [W-1:0] cur;
        cur = pending ? pend_data : d;
        if (!pending) begin
            in_data = d;
            in_req  = ~in_req;
            n_tog++;
        end
        pending = 1'b0;
        @(negedge clk);
        chk(in_ack == in_req, "R2 ack", in_ack, in_req);
        chk(out_req == 1'b1, "R2 req", out_req, 1);
        chk(out_data == cur, "R2 data", out_data, cur);
        a0 = in_ack;
        in_data = ~cur;
        for (int i = 0; i < rd; i++) begin
            @(negedge clk);
            chk(out_req == 1'b1, "R4 hold", out_req, 1);
            chk(out_data == cur, "R6 stable", out_data, cur);
        end
        out_ack = 1'b1;
        @(negedge clk);
        chk(out_req == 1'b0, "R4 drop", out_req, 0);
        chk(out_data == cur, "R6 held", out_data, cur);
        if (early) begin
            in_data   = d2;
            pend_data = d2;
            in_req    = ~in_req;
            n_tog++;
            pending   = 1'b1;
        end
        for (int i = 0; i < fd; i++) begin
            @(negedge clk);
            chk(out_req == 1'b0, "R5 low", out_req, 0);
            chk(in_ack == a0, "R5 ack", in_ack, a0);
        end
        out_ack = 1'b0;
        @(negedge clk);
        chk(out_req == 1'b0, "R5 idle", out_req, 0);
        chk(in_ack == a0, "R5 no early take", in_ack, a0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ack == 1'b0, "R1 ack", in_ack, 0);
        chk(out_req == 1'b0, "R1 req", out_req, 0);
        chk(out_data == '0, "R1 data", out_data, 0);

        for (int i = 0; i < 32; i++) begin
            logic [W-1:0] d;
            logic [W-1:0] d2;
            d  = W'((i * 37 + 5) & 8'hff);
            d2 = W'((i * 91 + 200) & 8'hff);
            token(d, i % 4, (i / 4) % 4, i[4], d2);
        end
        if (pending) token(pend_data, 1, 1, 1'b0, '0);

        // R8: an empty link ignores data changes
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] keep;
            logic ka;
            keep = out_data;
            ka = in_ack;
            in_data = W'(i * 53 + 1);
            @(negedge clk);
            chk(out_data == keep, "R8 data", out_data, keep);
            chk(in_ack == ka && out_req == 1'b0, "R8 ctrl", out_req, 0);
        end

        chk(n_rise == n_tog, "R7 count", n_rise, n_tog);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule